// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is a target on a two-wire serial bus that sits in front of a 2048-byte memory, addressed one byte at a time. The memory lives in internal registers. The block takes the clock line and the data line as plain inputs. It pulls the data line low through an open-drain enable and never drives it high. A bus master addresses the block with a one-byte header. The upper nibble of that header must match a fixed device code. The next three bits select one of eight 256-byte blocks, and the lowest bit picks the direction. Writes then carry a low address byte followed by any number of data bytes. Reads stream bytes from an internal pointer.

The block oversamples both bus lines with the system clock through a two-flop synchronizer, and it finds start, stop and clock edges on the synchronized samples. Its system clock must run at least eight times faster than the bus clock. A start or a stop cuts off the current operation at once. A start also readies the block for a fresh header byte, so a master can set the pointer with a write header and a low address byte, then turn around with a repeated start and read.

Top module: `twowire_mem_target`

## Requirements
- R1: After reset the data-line pull enable is off and the block is idle, waiting for a start.
- R2: A start (data falling while the clock is high) is accepted at any point, even in the middle of a byte. It abandons the current operation, and the next eight bits are taken as a header byte that is acknowledged as normal.
- R3: A stop (data rising while the clock is high) returns the block to idle with the data line released. A data byte cut short by a stop is not written to memory, and the bytes completed before it are kept.
- R4: Bits are taken most significant first, one per clock high phase, eight per byte. When a header byte whose bits 7:4 equal 1010 is received, the block pulls the data line low during the ninth clock.
- R5: When the header bits 7:4 differ from 1010, the block does not acknowledge that byte or any later byte, and it changes no memory until the next start.
- R6: In a write (header bit 0 = 0), the byte after the header sets address bits 7:0, and header bits 3:1 set address bits 10:8. Each following byte is stored at the current address and acknowledged, and the address then advances by one.
- R7: The address advances modulo 2048, so the byte after address 2047 goes to address 0. Reads wrap the same way.
- R8: In a read (header bit 0 = 1), the first byte sent is the one at the current internal pointer, and header bits 3:1 are ignored. The block sends each byte most significant bit first. It keeps sending the next byte in sequence for as long as the master pulls the data line low in the ninth clock.
- R9: When the master leaves the ninth clock of a read byte high (a not-acknowledge), the block stops sending. It leaves the data line released for every later clock until the next start.
- R10: The pull enable changes only while the bus clock is low, so the block never creates a start or a stop of its own.
- R11: A write header and a low address byte, followed by a repeated start and a read header, return the data stored at that address and at the addresses after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired level) |
| sda_pull | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The bench builds the block with its default values: an 11-bit address, which gives three block-select bits and the 1010 device code, and two synchronizer stages. With the full 11-bit space in place, the wrap from address 2047 to 0 can be reached directly by writing with block select 7 and low address 0xFF. The bus clock runs at 40 system clocks per bit, well above the eightfold minimum. So the synchronizer delay and the timing of the acknowledge release are exercised under realistic margins, while a start abort and a stop abort can still be placed in the middle of a byte.

// File: rtl/twm_pkg.sv
package twm_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HDR,
    ST_HDR_ACK,
    ST_LOADR,
    ST_LOADR_ACK,
    ST_WBYTE,
    ST_WBYTE_ACK,
    ST_RBYTE,
    ST_RACK,
    ST_DEAF
  } twm_state_e;

  localparam logic [3:0] TWM_DEV_CODE = 4'b1010;

endpackage

// File: rtl/twm_sync.sv
module twm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] line_in;
  logic [NLINES-1:0] line_s;
  logic [NLINES-1:0] line_d;

  assign line_in = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe      <= '1;
        line_d[g] <= 1'b1;
      end else begin
        pipe      <= {pipe[STAGES-2:0], line_in[g]};
        line_d[g] <= pipe[STAGES-1];
      end
    end
    assign line_s[g] = pipe[STAGES-1];
  end

  logic scl_now, scl_was, sda_now, sda_was;
  assign scl_now = line_s[0];
  assign scl_was = line_d[0];
  assign sda_now = line_s[1];
  assign sda_was = line_d[1];

  assign sda_s     = sda_now;
  assign scl_rise  = scl_now & ~scl_was;
  assign scl_fall  = ~scl_now & scl_was;
  assign start_det = scl_now & scl_was & sda_was & ~sda_now;
  assign stop_det  = scl_now & scl_was & ~sda_was & sda_now;

endmodule

// File: rtl/twm_mem.sv
module twm_mem #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/twm_engine.sv
module twm_engine
  import twm_pkg::*;
#(
  parameter int         ADDR_W   = 11,
  parameter logic [3:0] DEV_CODE = TWM_DEV_CODE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] ptr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic              sda_pull,
  output twm_state_e        state
);

  localparam int BLK_W = ADDR_W - 8;

  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic code_ok(input logic [7:0] hdr);
    return hdr[7:4] == DEV_CODE;
  endfunction

  logic [7:0]       rx;
  logic [7:0]       tx;
  logic [2:0]       bitcnt;
  logic             rx_full;
  logic             rd_dir;
  logic [BLK_W-1:0] blk;
  logic             mack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      rx        <= '0;
      tx        <= '0;
      bitcnt    <= '0;
      rx_full   <= 1'b0;
      rd_dir    <= 1'b0;
      blk       <= '0;
      mack      <= 1'b0;
      ptr       <= '0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
      sda_pull  <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      if (start_det) begin
        state    <= ST_HDR;
        bitcnt   <= '0;
        rx_full  <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        rx_full  <= 1'b0;
        sda_pull <= 1'b0;
      end else begin
        unique case (state)
          ST_HDR, ST_LOADR, ST_WBYTE: begin
            if (scl_rise && !rx_full) begin
              rx     <= {rx[6:0], sda_s};
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) rx_full <= 1'b1;
            end else if (scl_fall && rx_full) begin
              rx_full <= 1'b0;
              bitcnt  <= '0;
              if (state == ST_HDR) begin
                if (code_ok(rx)) begin
                  sda_pull <= 1'b1;
                  rd_dir   <= rx[0];
                  blk      <= rx[BLK_W:1];
                  state    <= ST_HDR_ACK;
                end else begin
                  state <= ST_DEAF;
                end
              end else if (state == ST_LOADR) begin
                ptr      <= {blk, rx};
                sda_pull <= 1'b1;
                state    <= ST_LOADR_ACK;
              end else begin
                mem_we    <= 1'b1;
                mem_waddr <= ptr;
                mem_wdata <= rx;
                ptr       <= bump(ptr);
                sda_pull  <= 1'b1;
                state     <= ST_WBYTE_ACK;
              end
            end
          end
          ST_HDR_ACK: begin
            if (scl_fall) begin
              if (rd_dir) begin
                tx       <= rd_data;
                ptr      <= bump(ptr);
                sda_pull <= ~rd_data[7];
                bitcnt   <= '0;
                state    <= ST_RBYTE;
              end else begin
                sda_pull <= 1'b0;
                state    <= ST_LOADR;
              end
            end
          end
          ST_LOADR_ACK, ST_WBYTE_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              state    <= ST_WBYTE;
            end
          end
          ST_RBYTE: begin
            if (scl_fall) begin
              if (bitcnt == 3'd7) begin
                sda_pull <= 1'b0;
                state    <= ST_RACK;
              end else begin
                tx       <= {tx[6:0], 1'b0};
                sda_pull <= ~tx[6];
                bitcnt   <= bitcnt + 3'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                tx       <= rd_data;
                ptr      <= bump(ptr);
                sda_pull <= ~rd_data[7];
                bitcnt   <= '0;
                state    <= ST_RBYTE;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: begin
            sda_pull <= 1'b0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/twowire_mem_target.sv
module twowire_mem_target
  import twm_pkg::*;
#(
  parameter int         ADDR_W      = 11,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_CODE    = TWM_DEV_CODE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull
);

  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic [ADDR_W-1:0] ptr;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [7:0]        mem_wdata;
  logic [7:0]        rd_data;
  twm_state_e        state;

  twm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twm_engine #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .ptr       (ptr),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .sda_pull  (sda_pull),
    .state     (state)
  );

  twm_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (ptr),
    .rdata (rd_data)
  );

endmodule

// File: rtl/twm_checker.sv
module twm_checker
  import twm_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sda_pull,
  input logic       start_det,
  input logic       stop_det,
  input logic       scl_fall,
  input logic       mem_we,
  input twm_state_e state
);

  assert_start_rearms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_HDR) && !sda_pull);

  assert_stop_idles_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE) && !sda_pull);

  assert_deaf_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEAF) |-> !sda_pull);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_pull);

  assert_pull_moves_on_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_fall || start_det || stop_det) |=> $stable(sda_pull));

  assert_single_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

endmodule

bind twowire_mem_target twm_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sda_pull  (sda_pull),
  .start_det (start_det),
  .stop_det  (stop_det),
  .scl_fall  (scl_fall),
  .mem_we    (mem_we),
  .state     (state)
);

// File: tb/twowire_mem_target_test.sv
`timescale 1ns/1ps
module twowire_mem_target_test;

  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic sda_bus;
  int   checks = 0;
  int   errors = 0;
  int   r10_viol = 0;
  logic prev_pull = 1'b0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull;

  twowire_mem_target uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl),
    .sda_i    (sda_bus),
    .sda_pull (sda_pull)
  );

  // R10: the pull enable must not change while the bench holds the clock high
  always @(negedge clk) begin
    if (rst_n && scl && (sda_pull !== prev_pull)) r10_viol++;
    prev_pull <= sda_pull;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic bus_stop();
    scl = 1'b0;   tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(Q);
    scl = 1'b1; tick(2*Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    ack = ~sda_bus;
    tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    d = '0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      scl = 1'b1; tick(Q);
      d = {d[6:0], sda_bus};
      tick(Q);
      scl = 1'b0;
    end
    tick(Q);
    sda_m = ~mack; tick(Q);
    scl = 1'b1;    tick(2*Q);
    scl = 1'b0;
    sda_m = 1'b1;
  endtask

  task automatic write_seq(input logic [7:0] hdr, input logic [7:0] lo,
                           input logic [7:0] d [], input string req);
    logic ack;
    bus_start();
    send_byte(hdr, ack); chk(req, "header ack", ack, 1);
    send_byte(lo, ack);  chk(req, "low address ack", ack, 1);
    foreach (d[i]) begin
      send_byte(d[i], ack); chk(req, "data ack", ack, 1);
    end
    bus_stop();
  endtask

  task automatic read_at(input logic [7:0] hdr, input logic [7:0] lo, output logic [7:0] d);
    logic ack;
    bus_start();
    send_byte(hdr, ack);
    send_byte(lo, ack);
    bus_start();
    send_byte(hdr | 8'h01, ack);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  task automatic t_reset();
    tick(5);
    chk("R1", "pull after reset", sda_pull, 0);
  endtask

  task automatic t_write_burst();
    write_seq(8'hAA, 8'h10, '{8'h11, 8'h22, 8'h33, 8'h44}, "R6");
    chk("R3", "pull after stop", sda_pull, 0);
  endtask

  task automatic t_random_read();
    logic ack;
    logic [7:0] d;
    int lows = 0;
    bus_start();
    send_byte(8'hAA, ack); chk("R4", "header ack", ack, 1);
    send_byte(8'h10, ack); chk("R11", "low address ack", ack, 1);
    bus_start();
    send_byte(8'hAB, ack); chk("R11", "read header ack", ack, 1);
    recv_byte(1'b1, d); chk("R11", "byte 0x510", d, 8'h11);
    recv_byte(1'b1, d); chk("R8", "byte 0x511", d, 8'h22);
    recv_byte(1'b0, d); chk("R8", "byte 0x512", d, 8'h33);
    for (int i = 0; i < 9; i++) begin
      sda_m = 1'b1; tick(Q);
      scl = 1'b1;   tick(Q);
      if (!sda_bus) lows++;
      tick(Q);
      scl = 1'b0;
    end
    chk("R9", "low bits after nack", lows, 0);
    bus_stop();
  endtask

  task automatic t_current_read();
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte(8'hA1, ack); chk("R8", "read header ack", ack, 1);
    recv_byte(1'b0, d); chk("R8", "pointer byte 0x513", d, 8'h44);
    bus_stop();
  endtask

  task automatic t_wrap();
    logic ack;
    logic [7:0] d;
    write_seq(8'hAE, 8'hFF, '{8'hA5, 8'h5A}, "R7");
    bus_start();
    send_byte(8'hAE, ack);
    send_byte(8'hFF, ack);
    bus_start();
    send_byte(8'hAF, ack);
    recv_byte(1'b1, d); chk("R7", "byte 0x7FF", d, 8'hA5);
    recv_byte(1'b0, d); chk("R7", "byte 0x000 after wrap", d, 8'h5A);
    bus_stop();
  endtask

  task automatic t_bad_code();
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte(8'h9A, ack); chk("R5", "foreign header ack", ack, 0);
    send_byte(8'h10, ack); chk("R5", "later byte ack", ack, 0);
    send_byte(8'hEE, ack); chk("R5", "data byte ack", ack, 0);
    bus_stop();
    read_at(8'hAA, 8'h10, d);
    chk("R5", "0x510 untouched", d, 8'h11);
  endtask

  task automatic t_stop_abort();
    logic ack;
    logic [7:0] d;
    write_seq(8'hAA, 8'h20, '{8'h01, 8'h02}, "R6");
    bus_start();
    send_byte(8'hAA, ack);
    send_byte(8'h20, ack);
    send_byte(8'h77, ack); chk("R3", "data ack before abort", ack, 1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
    bus_stop();
    tick(5);
    chk("R3", "pull after mid-byte stop", sda_pull, 0);
    read_at(8'hAA, 8'h20, d); chk("R3", "completed byte kept", d, 8'h77);
    read_at(8'hAA, 8'h21, d); chk("R3", "partial byte dropped", d, 8'h02);
  endtask

  task automatic t_start_abort();
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte(8'hAA, ack);
    send_byte(8'h30, ack);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    bus_start();
    send_byte(8'hAA, ack); chk("R2", "header ack after abort", ack, 1);
    send_byte(8'h30, ack); chk("R2", "low address ack", ack, 1);
    send_byte(8'h66, ack); chk("R2", "data ack", ack, 1);
    bus_stop();
    read_at(8'hAA, 8'h30, d); chk("R2", "byte 0x530", d, 8'h66);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(8);
    rst_n = 1'b1;
    t_reset();
    t_write_burst();
    t_random_read();
    t_current_read();
    t_wrap();
    t_bad_code();
    t_stop_abort();
    t_start_abort();
    chk("R10", "pull changes while clock high", r10_viol, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule